// File: doc/BRIEF.md
# Multi-Plane Block Erase Sequencer

This block sits on the host side of a NAND flash channel and drives one die through a block erase. It can erase a single block, or one block in each of several planes. A request gives a plane mask, a block number and a die number. The block first polls the die's status until the die reports ready. It then sends one erase setup per selected plane, starting at the lowest plane. Each setup is the setup opcode followed by three row-address bytes. Every plane except the last is closed with the queue confirm, and the last plane is closed with the final confirm.

After the final confirm the block waits out the erase by polling status at a fixed interval. It then reports pass, fail or timeout through a one-cycle completion pulse. On targets with more than one die, each status poll uses the die-selective status opcode followed by that die's row address, so that only the addressed die drives the data bus. A single-die build uses the plain status opcode instead. A cycle counter bounds every wait, and a die that stays busy past the limit ends the request with a timeout.

Top module: `erase_seq`

## Requirements
- R1: A `start` pulse with a nonzero `req_mask` is accepted only while `busy` is low, and `busy` is high on the next cycle. A `start` with an all-zero mask, or any `start` while `busy` is high, has no effect on the bus or on the results.
- R2: No erase setup opcode (60h) is sent unless the latest status read showed RDY (bit 6) and ARDY (bit 5) both set. This applies to the first plane and also to each plane that follows a queue confirm.
- R3: Each erase setup is the command byte 60h followed by exactly three address bytes, least significant byte first. The address is a 24-bit row with the page in bits [5:0] (always zero), the plane in bits [7:6], the block in bits [17:8] and the die in bit 18.
- R4: Planes are erased in ascending index order. Every plane's address is followed by command D1h, except the highest selected plane, whose address is followed by D0h.
- R5: With more than one die, each status poll is command 78h, then three address bytes carrying the die and block with the plane and page fields zero, then one `stat_rd` cycle. With a single die, each poll is command 70h, then one `stat_rd` cycle. `stat_data` is sampled on the cycle after `stat_rd`.
- R6: After a D1h or D0h confirm, the next bus cycle comes exactly POLL_GAP+1 cycles later. Every poll that finds the die busy is also followed by POLL_GAP idle cycles.
- R7: When a status poll after D0h shows RDY and ARDY set, `done` pulses for one cycle. At that point `fail` equals status bit 0 and `timeout` is 0. Both results hold their values until the next `done`.
- R8: If no ready status is seen within MAX_WAIT cycles of the start of a wait, the request ends with `done`, `timeout`=1 and `fail`=0.
- R9: At most one bus cycle is issued per clock. `bus_valid` and `stat_rd` are never high together, and both stay low while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| req_mask | input | PLANES | Planes to erase |
| req_block | input | BLK_W | Block number within each plane |
| req_die | input | DIE_IW | Die number |
| bus_valid | output | 1 | A command or address byte is on `bus_data` this cycle |
| bus_cmd | output | 1 | 1: command byte, 0: address byte |
| bus_data | output | 8 | Byte driven to the die |
| stat_rd | output | 1 | Status read strobe |
| stat_data | input | 8 | Status byte, valid the cycle after `stat_rd` |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Erase failed (status bit 0) |
| timeout | output | 1 | Wait limit exceeded |

## Verification
The assertions assume that `stat_data` is a plain function of the die's state and that a request is only raised with the reset released. They also assume POLL_GAP is at least one, so a confirm is never directly followed by another bus cycle. The bench's die model keeps to these assumptions. It drives `stat_data` combinationally from its own busy counter, and it applies `start` only on falling edges. Between tests it waits until the model die is idle, so that the readiness check before each request never runs into the wait limit unintentionally.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
   localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
   localparam logic [7:0] OP_QUEUE_CONF  = 8'hD1;
   localparam logic [7:0] OP_FINAL_CONF  = 8'hD0;
   localparam logic [7:0] OP_STAT_ALL    = 8'h70;
   localparam logic [7:0] OP_STAT_DIE    = 8'h78;

   localparam int ROW_W    = 24;
   localparam int BIT_RDY  = 6;
   localparam int BIT_ARDY = 5;
   localparam int BIT_FAIL = 0;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PCMD,
      S_PADR,
      S_PRD,
      S_CAP,
      S_GAP,
      S_ECMD,
      S_EADR,
      S_ECONF
   } seq_state_t;
endpackage

// File: rtl/erase_row_fmt.sv
module erase_row_fmt #(
   parameter int PAGE_W = 6,
   parameter int PLW    = 2,
   parameter int PLI    = 2,
   parameter int BLK_W  = 10,
   parameter int DW     = 1,
   parameter int DI     = 1
) (
   input  logic [PLI-1:0]   plane,
   input  logic [BLK_W-1:0] blk,
   input  logic [DI-1:0]    die,
   output logic [23:0]      row
);
   localparam int PL_LSB  = PAGE_W;
   localparam int BLK_LSB = PAGE_W + PLW;
   localparam int DIE_LSB = PAGE_W + PLW + BLK_W;

   logic [23:0] plane_part, blk_part, die_part;

   assign blk_part = 24'(blk) << BLK_LSB;

   generate
      if (PLW > 0) begin : g_plane
         assign plane_part = 24'(plane[PLW-1:0]) << PL_LSB;
      end else begin : g_noplane
         assign plane_part = '0;
      end
      if (DW > 0) begin : g_die
         assign die_part = 24'(die[DW-1:0]) << DIE_LSB;
      end else begin : g_nodie
         assign die_part = '0;
      end
   endgenerate

   assign row = plane_part | blk_part | die_part;
endmodule

// File: rtl/erase_plane_pick.sv
module erase_plane_pick #(
   parameter int PLANES = 4,
   parameter int PLI    = 2
) (
   input  logic [PLANES-1:0] mask,
   output logic [PLI-1:0]    idx,
   output logic              any,
   output logic              more
);
   always_comb begin
      idx = '0;
      for (int i = PLANES - 1; i >= 0; i--) begin
         if (mask[i]) idx = PLI'(i);
      end
   end

   assign any  = |mask;
   assign more = ($countones(mask) > 1);
endmodule

// File: rtl/erase_wait_timer.sv
module erase_wait_timer #(
   parameter int MAX_WAIT = 100000,
   parameter int GAP      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic gap_start,
   input  logic in_gap,
   output logic expired,
   output logic gap_last
);
   localparam int CW = $clog2(MAX_WAIT + 1);
   localparam int GW = $clog2(GAP + 1);

   logic [CW-1:0] cnt;
   logic [GW-1:0] gcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt <= '0;
      else if (clr)                   cnt <= '0;
      else if (cnt != CW'(MAX_WAIT))  cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         gcnt <= '0;
      else if (gap_start) gcnt <= '0;
      else if (in_gap)    gcnt <= gcnt + 1'b1;
   end

   assign expired  = (cnt == CW'(MAX_WAIT));
   assign gap_last = (gcnt == GW'(GAP - 1));
endmodule

// File: rtl/erase_seq.sv
module erase_seq
   import erase_seq_pkg::*;
#(
   parameter int PLANES   = 4,
   parameter int DIES     = 2,
   parameter int BLK_W    = 10,
   parameter int PAGE_W   = 6,
   parameter int MAX_WAIT = 100000,
   parameter int POLL_GAP = 8,
   localparam int DIE_IW  = (DIES > 1) ? $clog2(DIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PLANES-1:0] req_mask,
   input  logic [BLK_W-1:0]  req_block,
   input  logic [DIE_IW-1:0] req_die,
   output logic              bus_valid,
   output logic              bus_cmd,
   output logic [7:0]        bus_data,
   output logic              stat_rd,
   input  logic [7:0]        stat_data,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              timeout
);
   localparam int PLW = (PLANES > 1) ? $clog2(PLANES) : 0;
   localparam int PLI = (PLW > 0) ? PLW : 1;
   localparam int DW  = (DIES > 1) ? $clog2(DIES) : 0;

   initial begin
      if (PLANES < 1 || (PLANES & (PLANES - 1)) != 0)
         $error("PLANES must be a power of two");
      if (DIES < 1 || (DIES & (DIES - 1)) != 0)
         $error("DIES must be a power of two");
      if (PAGE_W + PLW + BLK_W + DW > ROW_W)
         $error("row fields exceed three address bytes");
      if (POLL_GAP < 1) $error("POLL_GAP must be at least 1");
      if (MAX_WAIT < 4) $error("MAX_WAIT too small");
   end

   seq_state_t        state;
   logic [PLANES-1:0] pend;
   logic [BLK_W-1:0]  blk_q;
   logic [DIE_IW-1:0] die_q;
   logic [1:0]        aidx;
   logic              post;
   logic              done_q, fail_q, to_q;

   logic [PLI-1:0]    cur_idx;
   logic              pend_any, pend_more;
   logic [23:0]       er_row, st_row;
   logic              expired, gap_last;
   logic              accept, die_ready, t_clr, g_start;
   logic [7:0]        stat_op;
   logic              stat_has_addr;

   generate
      if (DIES > 1) begin : g_multi
         assign stat_op       = OP_STAT_DIE;
         assign stat_has_addr = 1'b1;
      end else begin : g_single
         assign stat_op       = OP_STAT_ALL;
         assign stat_has_addr = 1'b0;
      end
   endgenerate

   erase_plane_pick #(.PLANES(PLANES), .PLI(PLI)) u_pick (
      .mask (pend),
      .idx  (cur_idx),
      .any  (pend_any),
      .more (pend_more)
   );

   erase_row_fmt #(
      .PAGE_W(PAGE_W), .PLW(PLW), .PLI(PLI), .BLK_W(BLK_W), .DW(DW), .DI(DIE_IW)
   ) u_er_row (
      .plane (cur_idx),
      .blk   (blk_q),
      .die   (die_q),
      .row   (er_row)
   );

   erase_row_fmt #(
      .PAGE_W(PAGE_W), .PLW(PLW), .PLI(PLI), .BLK_W(BLK_W), .DW(DW), .DI(DIE_IW)
   ) u_st_row (
      .plane ('0),
      .blk   (blk_q),
      .die   (die_q),
      .row   (st_row)
   );

   assign accept    = (state == S_IDLE) && start && (|req_mask);
   assign die_ready = stat_data[BIT_RDY] && stat_data[BIT_ARDY];
   assign t_clr     = accept || (state == S_ECONF);
   assign g_start   = (state == S_ECONF) ||
                      ((state == S_CAP) && !die_ready && !expired);

   erase_wait_timer #(.MAX_WAIT(MAX_WAIT), .GAP(POLL_GAP)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (t_clr),
      .gap_start (g_start),
      .in_gap    (state == S_GAP),
      .expired   (expired),
      .gap_last  (gap_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         pend   <= '0;
         blk_q  <= '0;
         die_q  <= '0;
         aidx   <= '0;
         post   <= 1'b0;
         done_q <= 1'b0;
         fail_q <= 1'b0;
         to_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (accept) begin
                  pend  <= req_mask;
                  blk_q <= req_block;
                  die_q <= req_die;
                  post  <= 1'b0;
                  state <= S_PCMD;
               end
            end
            S_PCMD: begin
               aidx  <= '0;
               state <= stat_has_addr ? S_PADR : S_PRD;
            end
            S_PADR: begin
               aidx <= aidx + 1'b1;
               if (aidx == 2'd2) state <= S_PRD;
            end
            S_PRD: state <= S_CAP;
            S_CAP: begin
               if (die_ready) begin
                  if (post) begin
                     state  <= S_IDLE;
                     done_q <= 1'b1;
                     fail_q <= stat_data[BIT_FAIL];
                     to_q   <= 1'b0;
                  end else begin
                     state <= S_ECMD;
                  end
               end else if (expired) begin
                  state  <= S_IDLE;
                  done_q <= 1'b1;
                  fail_q <= 1'b0;
                  to_q   <= 1'b1;
               end else begin
                  state <= S_GAP;
               end
            end
            S_GAP: if (gap_last) state <= S_PCMD;
            S_ECMD: begin
               aidx  <= '0;
               state <= S_EADR;
            end
            S_EADR: begin
               aidx <= aidx + 1'b1;
               if (aidx == 2'd2) state <= S_ECONF;
            end
            S_ECONF: begin
               pend[cur_idx] <= 1'b0;
               post          <= !pend_more;
               state         <= S_GAP;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_valid = 1'b0;
      bus_cmd   = 1'b0;
      bus_data  = 8'h00;
      unique case (state)
         S_PCMD: begin
            bus_valid = 1'b1;
            bus_cmd   = 1'b1;
            bus_data  = stat_op;
         end
         S_PADR: begin
            bus_valid = 1'b1;
            bus_data  = st_row[8*aidx +: 8];
         end
         S_ECMD: begin
            bus_valid = 1'b1;
            bus_cmd   = 1'b1;
            bus_data  = OP_ERASE_SETUP;
         end
         S_EADR: begin
            bus_valid = 1'b1;
            bus_data  = er_row[8*aidx +: 8];
         end
         S_ECONF: begin
            bus_valid = 1'b1;
            bus_cmd   = 1'b1;
            bus_data  = (pend_any && pend_more) ? OP_QUEUE_CONF : OP_FINAL_CONF;
         end
         default: ;
      endcase
   end

   assign stat_rd = (state == S_PRD);
   assign busy    = (state != S_IDLE);
   assign done    = done_q;
   assign fail    = fail_q;
   assign timeout = to_q;
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
   parameter int PLANES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [PLANES-1:0] req_mask,
   input logic              bus_valid,
   input logic              bus_cmd,
   input logic [7:0]        bus_data,
   input logic              stat_rd,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic              timeout
);
   p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (|req_mask)) |=> busy);

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bus_valid && !stat_rd));

   p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && stat_rd));

   p_read_after_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |-> $past(bus_valid));

   p_gap_after_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_cmd && bus_data == 8'hD0) |=> !bus_valid);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(fail) || !$stable(timeout)) |-> done);

   p_timeout_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && timeout) |-> !fail);
endmodule

bind erase_seq erase_seq_chk #(.PLANES(PLANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .req_mask  (req_mask),
   .bus_valid (bus_valid),
   .bus_cmd   (bus_cmd),
   .bus_data  (bus_data),
   .stat_rd   (stat_rd),
   .busy      (busy),
   .done      (done),
   .fail      (fail),
   .timeout   (timeout)
);

// File: tb/erase_seq_bench.sv
module erase_seq_bench;
   localparam int PLANES   = 4;
   localparam int DIES     = 2;
   localparam int BLK_W    = 10;
   localparam int PAGE_W   = 6;
   localparam int MAX_WAIT = 300;
   localparam int GAP      = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [PLANES-1:0] req_mask = '0;
   logic [BLK_W-1:0]  req_block = '0;
   logic [0:0]        req_die = '0;
   logic              bus_valid, bus_cmd, stat_rd, busy, done, fail, timeout;
   logic [7:0]        bus_data, stat_data;

   int vectors = 0;
   int errors  = 0;
   int cyc     = 0;

   logic [8:0] exp_bus[$];
   logic [1:0] exp_res[$];

   int  busy_cnt   = 0;
   int  preload    = 0;
   int  model_bers = 60;
   bit  model_fail = 1'b0;
   int  stat_left  = 0;
   int  stat_idx   = 0;
   int  conf_cyc   = -1;
   logic [23:0] stat_row_exp = '0;

   always #2 clk = ~clk;

   erase_seq #(
      .PLANES(PLANES), .DIES(DIES), .BLK_W(BLK_W), .PAGE_W(PAGE_W),
      .MAX_WAIT(MAX_WAIT), .POLL_GAP(GAP)
   ) u_erase_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .req_mask(req_mask),
      .req_block(req_block), .req_die(req_die), .bus_valid(bus_valid),
      .bus_cmd(bus_cmd), .bus_data(bus_data), .stat_rd(stat_rd),
      .stat_data(stat_data), .busy(busy), .done(done), .fail(fail),
      .timeout(timeout)
   );

   // die model: RDY bit 6, ARDY bit 5, FAIL bit 0
   assign stat_data = (busy_cnt > 0) ? 8'h00 : {1'b0, 1'b1, 1'b1, 4'b0000, model_fail};

   task automatic check(input bit ok, input string req, input int act, input int expv);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      cyc++;
      if (preload > 0) begin
         busy_cnt = preload;
         preload  = 0;
      end
      if (rst_n && bus_valid) begin
         if (conf_cyc >= 0) begin
            check(cyc - conf_cyc == GAP + 1, "R6 confirm-to-next spacing", cyc - conf_cyc, GAP + 1);
            conf_cyc = -1;
         end
         if (bus_cmd && (bus_data == 8'h78 || bus_data == 8'h70)) begin
            check(bus_data == 8'h78, "R5 die-selective status opcode", bus_data, 8'h78);
            stat_left = 3;
            stat_idx  = 0;
         end else if (!bus_cmd && stat_left > 0) begin
            check(bus_data == stat_row_exp[8*stat_idx +: 8], "R5 status row byte",
                  bus_data, stat_row_exp[8*stat_idx +: 8]);
            stat_left--;
            stat_idx++;
         end else if (exp_bus.size() == 0) begin
            check(1'b0, "R1 unexpected bus cycle", {bus_cmd, bus_data}, 0);
         end else begin
            logic [8:0] e;
            e = exp_bus.pop_front();
            check({bus_cmd, bus_data} == e, "R3/R4 erase bus item", {bus_cmd, bus_data}, e);
            if (bus_cmd && bus_data == 8'h60)
               check(busy_cnt == 0, "R2 setup only when ready", busy_cnt, 0);
            if (bus_cmd && bus_data == 8'hD1) begin
               busy_cnt = 3;
               conf_cyc = cyc;
            end
            if (bus_cmd && bus_data == 8'hD0) begin
               busy_cnt = model_bers;
               conf_cyc = cyc;
            end
         end
      end else if (busy_cnt > 0) begin
         busy_cnt--;
      end
      if (rst_n && stat_rd)
         check(stat_left == 0, "R5 read after full status poll", stat_left, 0);
      if (rst_n && done) begin
         if (exp_res.size() == 0) begin
            check(1'b0, "R1 unexpected completion", {timeout, fail}, 0);
         end else begin
            logic [1:0] r;
            r = exp_res.pop_front();
            check({timeout, fail} == r, (r[1] ? "R8 timeout result" : "R7 pass/fail result"),
                  {timeout, fail}, r);
         end
      end
   end

   task automatic run_erase(input logic [3:0] m, input logic [9:0] b, input logic d,
                            input bit f, input int bers, input int pre, input bit exp_to,
                            input bit poke);
      int last;
      last = 0;
      for (int p = 0; p < PLANES; p++) if (m[p]) last = p;
      for (int p = 0; p < PLANES; p++) begin
         if (m[p]) begin
            logic [23:0] row;
            row = (24'(d) << 18) | (24'(b) << 8) | (24'(p) << 6);
            exp_bus.push_back({1'b1, 8'h60});
            exp_bus.push_back({1'b0, row[7:0]});
            exp_bus.push_back({1'b0, row[15:8]});
            exp_bus.push_back({1'b0, row[23:16]});
            exp_bus.push_back({1'b1, (p == last) ? 8'hD0 : 8'hD1});
         end
      end
      exp_res.push_back(exp_to ? 2'b10 : {1'b0, f});
      @(negedge clk);
      model_fail   = f;
      model_bers   = bers;
      preload      = pre;
      stat_row_exp = (24'(d) << 18) | (24'(b) << 8);
      start     = 1'b1;
      req_mask  = m;
      req_block = b;
      req_die   = d;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R1 accept sets busy", busy, 1);
      if (poke) begin
         repeat (5) @(negedge clk);
         start    = 1'b1;
         req_mask = 4'b1000;
         @(negedge clk);
         start    = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R7 idle after completion", busy, 0);
      while (busy_cnt != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !bus_valid && !stat_rd, "R9 reset state",
            {busy, done, bus_valid, stat_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_erase(4'b0001, 10'd5,   1'b0, 1'b0, 60,   0,  1'b0, 1'b0); // R3 single plane pass
      run_erase(4'b0101, 10'h3A,  1'b1, 1'b0, 80,   0,  1'b0, 1'b0); // R4 two planes
      run_erase(4'b1111, 10'h3FF, 1'b1, 1'b1, 50,   0,  1'b0, 1'b0); // R7 fail bit
      run_erase(4'b1000, 10'd1,   1'b0, 1'b0, 40,   45, 1'b0, 1'b0); // R2 die busy at start
      run_erase(4'b0110, 10'h100, 1'b0, 1'b0, 1000, 0,  1'b1, 1'b0); // R8 timeout
      run_erase(4'b0011, 10'd9,   1'b1, 1'b0, 30,   0,  1'b0, 1'b1); // R1 start while busy

      // R1: all-zero mask is ignored
      @(negedge clk);
      start    = 1'b1;
      req_mask = 4'b0000;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b0, "R1 zero mask ignored", busy, 0);
      repeat (10) @(negedge clk);
      check(!bus_valid && !done, "R1 zero mask no activity", {bus_valid, done}, 0);

      check(exp_bus.size() == 0, "R4 all erase items seen", exp_bus.size(), 0);
      check(exp_res.size() == 0, "R7 all results seen", exp_res.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      vectors++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule